// File: doc/BRIEF.md
# Instruction Address Patch-and-Breakpoint Unit

This debug block sits on two address streams of a processor: instruction fetches and literal (constant-pool) loads. A small bank of programmable comparators watches both streams. When an enabled comparator hits, the unit either swaps the access address for a slot in a remap table held in system memory, so a patched word is returned in place of the original, or it raises a breakpoint request towards the debug logic. Each table slot is chosen by the number of the comparator that hit.

Software programs the unit through a single-cycle register port. Word 0 is control, word 1 is the table base, and words 2 to 9 configure comparators 0 to 7. Comparators 0 to 5 serve instruction fetches. Comparators 6 and 7 serve literal loads. Results come out one clock after the address strobe, each on its own valid strobe.

Top module: `addr_patch_unit`

## Requirements
- R1: After reset, control (word 0) reads 0x0000_0260. In this value, bits 11:8 give the literal comparator count (2), bits 7:4 and 14:12 together give the instruction comparator count (6), and all other bits are 0. No output strobe, match or breakpoint is asserted.
- R2: An enabled instruction comparator in mode 0 (remap) hits when the fetch word matches its stored address. One cycle later the unit outputs match=1 and address = base + 4*index + fetch_addr[1:0].
- R3: A fetch that no comparator hits comes out one cycle later with its address unchanged, and with match and breakpoint both 0.
- R4: When several comparators hit in the same cycle, the lowest-numbered one decides the result.
- R5: Mode 1 breaks only when fetch_addr[1]=0, mode 2 only when fetch_addr[1]=1, and mode 3 on either value. A break gives breakpoint=1 and match=0, and the address passes through unchanged.
- R6: Comparators 6 and 7 compare only literal-load addresses, and they always remap whatever their mode field holds. Their slots lie at base+24 and base+28. Instruction comparators never hit literal loads.
- R7: While control bit 0 (enable) is 0, neither port reports a match or a breakpoint.
- R8: A write to control is discarded unless bit 1 of the written data is 1. Bit 1 always reads back as 0.
- R9: Base (word 1) ignores written bits 4:0 and reads them back as 0.
- R10: A comparator word holds its enable in bit 0, the word address in bits 29:2 and the mode in bits 31:30, and it reads back in the same layout. A fetch address with bits 31:30 not equal to 0 never hits.
- R11: Each output valid strobe is high for exactly one cycle after each input strobe and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| if_valid_i | input | 1 | Instruction fetch strobe |
| if_addr_i | input | 32 | Fetch address |
| if_valid_o | output | 1 | Fetch result strobe |
| if_addr_o | output | 32 | Fetch address after remap |
| if_match_o | output | 1 | Fetch was remapped |
| if_bkpt_o | output | 1 | Breakpoint request |
| lit_valid_i | input | 1 | Literal load strobe |
| lit_addr_i | input | 32 | Literal load address |
| lit_valid_o | output | 1 | Literal result strobe |
| lit_addr_o | output | 32 | Literal address after remap |
| lit_match_o | output | 1 | Literal load was remapped |

## Verification
The bench builds the unit with its default counts: six instruction comparators and two literal comparators. With these counts the table is eight slots deep and the base is 32-byte aligned. This lets the bench reach both literal slots at the top of the table, priority ties between a remap comparator and a breakpoint comparator at the same address, and all three halfword breakpoint modes. A behavioural model predicts every output strobe, flag and address on each clock, including cycles where a register write and a fetch arrive together.

// File: rtl/apu_pkg.sv
package apu_pkg;
  typedef enum logic [1:0] {
    MODE_REMAP   = 2'd0,
    MODE_BP_LO   = 2'd1,
    MODE_BP_HI   = 2'd2,
    MODE_BP_BOTH = 2'd3
  } cmp_mode_e;

  typedef struct packed {
    cmp_mode_e   mode;
    logic [27:0] waddr;
    logic        en;
  } cmp_cfg_t;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_BASE = 1;
  localparam int unsigned REG_CMP0 = 2;
endpackage

// File: rtl/apu_regs.sv
module apu_regs
  import apu_pkg::*;
#(
  parameter int unsigned N_INSTR = 6,
  parameter int unsigned N_LIT   = 2,
  parameter int unsigned RAW     = 4,
  localparam int unsigned N_CMP  = N_INSTR + N_LIT,
  localparam int unsigned AL     = $clog2(N_CMP) + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_valid_i,
  input  logic                   reg_write_i,
  input  logic [RAW-1:0]         reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  output logic                   en_o,
  output logic [31-AL:0]         base_o,
  output cmp_cfg_t [N_CMP-1:0]   cfg_o
);
  localparam logic [6:0] NUM_INSTR = 7'(N_INSTR);
  localparam logic [3:0] NUM_LIT   = 4'(N_LIT);

  logic                 en_q;
  logic [31-AL:0]       base_q;
  cmp_cfg_t [N_CMP-1:0] cfg_q;
  logic                 wr;

  assign wr = reg_valid_i && reg_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
      cfg_q  <= '0;
    end else if (wr) begin
      if (reg_addr_i == RAW'(REG_CTRL) && reg_wdata_i[1]) en_q <= reg_wdata_i[0];
      if (reg_addr_i == RAW'(REG_BASE)) base_q <= reg_wdata_i[31:AL];
      for (int i = 0; i < N_CMP; i++) begin
        if (reg_addr_i == RAW'(REG_CMP0 + i)) begin
          cfg_q[i].en    <= reg_wdata_i[0];
          cfg_q[i].waddr <= reg_wdata_i[29:2];
          cfg_q[i].mode  <= cmp_mode_e'(reg_wdata_i[31:30]);
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == RAW'(REG_CTRL))
      reg_rdata_o = {17'b0, NUM_INSTR[6:4], NUM_LIT, NUM_INSTR[3:0], 3'b0, en_q};
    if (reg_addr_i == RAW'(REG_BASE))
      reg_rdata_o = {base_q, {AL{1'b0}}};
    for (int i = 0; i < N_CMP; i++) begin
      if (reg_addr_i == RAW'(REG_CMP0 + i))
        reg_rdata_o = {cfg_q[i].mode, cfg_q[i].waddr, 1'b0, cfg_q[i].en};
    end
  end

  assign en_o   = en_q;
  assign base_o = base_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/apu_cmp.sv
module apu_cmp
  import apu_pkg::*;
#(
  parameter bit LITERAL = 1'b0
) (
  input  logic        en_i,
  input  cmp_cfg_t    cfg_i,
  input  logic [31:0] addr_i,
  output logic        hit_o,
  output logic        bp_o
);
  logic word_eq;
  assign word_eq = en_i && cfg_i.en && (addr_i[31:30] == 2'b00) &&
                   (addr_i[29:2] == cfg_i.waddr);

  generate
    if (LITERAL) begin : g_lit
      // literal slots ignore mode: always remap
      assign hit_o = word_eq;
      assign bp_o  = 1'b0;
    end else begin : g_instr
      always_comb begin
        unique case (cfg_i.mode)
          MODE_BP_LO: hit_o = word_eq && !addr_i[1];
          MODE_BP_HI: hit_o = word_eq &&  addr_i[1];
          default:    hit_o = word_eq;
        endcase
      end
      assign bp_o = (cfg_i.mode != MODE_REMAP);
    end
  endgenerate
endmodule

// File: rtl/apu_prio.sv
module apu_prio #(
  parameter int unsigned N  = 6,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hit_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/addr_patch_unit.sv
module addr_patch_unit
  import apu_pkg::*;
#(
  parameter int unsigned N_INSTR = 6,
  parameter int unsigned N_LIT   = 2,
  localparam int unsigned N_CMP  = N_INSTR + N_LIT,
  localparam int unsigned CIW    = $clog2(N_CMP),
  localparam int unsigned AL     = CIW + 2,
  localparam int unsigned RAW    = $clog2(N_CMP + 2),
  localparam int unsigned IIW    = (N_INSTR > 1) ? $clog2(N_INSTR) : 1,
  localparam int unsigned LIW    = (N_LIT > 1) ? $clog2(N_LIT) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_valid_i,
  input  logic           reg_write_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  input  logic           if_valid_i,
  input  logic [31:0]    if_addr_i,
  output logic           if_valid_o,
  output logic [31:0]    if_addr_o,
  output logic           if_match_o,
  output logic           if_bkpt_o,
  input  logic           lit_valid_i,
  input  logic [31:0]    lit_addr_i,
  output logic           lit_valid_o,
  output logic [31:0]    lit_addr_o,
  output logic           lit_match_o
);
  logic                 ctrl_en;
  logic [31-AL:0]       base_hi;
  logic [31:0]          base_full;
  cmp_cfg_t [N_CMP-1:0] cfg;
  logic [N_INSTR-1:0]   i_hit, i_bp;
  logic [N_LIT-1:0]     l_hit;
  logic                 i_any, l_any;
  logic [IIW-1:0]       i_idx;
  logic [LIW-1:0]       l_idx;
  logic                 i_is_bp;
  logic [CIW-1:0]       i_slot, l_slot;

  assign base_full = {base_hi, {AL{1'b0}}};

  apu_regs #(.N_INSTR(N_INSTR), .N_LIT(N_LIT), .RAW(RAW)) u_regs (
    .clk_i, .rst_ni, .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .en_o(ctrl_en), .base_o(base_hi), .cfg_o(cfg)
  );

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    if (g < N_INSTR) begin : g_i
      apu_cmp #(.LITERAL(1'b0)) u_cmp (
        .en_i(ctrl_en), .cfg_i(cfg[g]), .addr_i(if_addr_i),
        .hit_o(i_hit[g]), .bp_o(i_bp[g])
      );
    end else begin : g_l
      logic unused_bp;
      apu_cmp #(.LITERAL(1'b1)) u_cmp (
        .en_i(ctrl_en), .cfg_i(cfg[g]), .addr_i(lit_addr_i),
        .hit_o(l_hit[g-N_INSTR]), .bp_o(unused_bp)
      );
    end
  end

  apu_prio #(.N(N_INSTR)) u_prio_i (.hit_i(i_hit), .any_o(i_any), .idx_o(i_idx));
  apu_prio #(.N(N_LIT))   u_prio_l (.hit_i(l_hit), .any_o(l_any), .idx_o(l_idx));

  assign i_is_bp = i_bp[i_idx];
  assign i_slot  = CIW'(i_idx);
  assign l_slot  = CIW'(l_idx) + CIW'(N_INSTR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_valid_o  <= 1'b0;
      if_addr_o   <= '0;
      if_match_o  <= 1'b0;
      if_bkpt_o   <= 1'b0;
      lit_valid_o <= 1'b0;
      lit_addr_o  <= '0;
      lit_match_o <= 1'b0;
    end else begin
      if_valid_o  <= if_valid_i;
      if_match_o  <= if_valid_i && i_any && !i_is_bp;
      if_bkpt_o   <= if_valid_i && i_any && i_is_bp;
      lit_valid_o <= lit_valid_i;
      lit_match_o <= lit_valid_i && l_any;
      if (if_valid_i)
        if_addr_o <= (i_any && !i_is_bp) ? {base_hi, i_slot, if_addr_i[1:0]} : if_addr_i;
      if (lit_valid_i)
        lit_addr_o <= l_any ? {base_hi, l_slot, lit_addr_i[1:0]} : lit_addr_i;
    end
  end
endmodule

// File: rtl/apu_checker.sv
module apu_checker #(
  parameter int unsigned N_INSTR = 6,
  parameter int unsigned N_LIT   = 2,
  parameter int unsigned RAW     = 4,
  localparam int unsigned AL     = $clog2(N_INSTR + N_LIT) + 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           reg_valid_i,
  input logic           reg_write_i,
  input logic [RAW-1:0] reg_addr_i,
  input logic [31:0]    reg_wdata_i,
  input logic           if_valid_i,
  input logic [31:0]    if_addr_i,
  input logic           if_valid_o,
  input logic [31:0]    if_addr_o,
  input logic           if_match_o,
  input logic           if_bkpt_o,
  input logic           lit_match_o,
  input logic [31:0]    lit_addr_o,
  input logic           en_q,
  input logic [31:0]    base_q
);
  assert_excl_kind_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_match_o |-> !if_bkpt_o);

  assert_bp_passthru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_bkpt_o |-> if_addr_o == $past(if_addr_i));

  assert_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_valid_i |=> (!if_valid_o && !if_match_o && !if_bkpt_o));

  assert_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (!if_match_o && !if_bkpt_o && !lit_match_o));

  assert_in_table_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_match_o |-> if_addr_o[31:AL] == $past(base_q[31:AL]));

  assert_lit_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lit_match_o |-> lit_addr_o[AL-1:2] >= (AL-2)'(N_INSTR));

  assert_key_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && reg_write_i && reg_addr_i == '0 && !reg_wdata_i[1]) |=> $stable(en_q));
endmodule

bind addr_patch_unit apu_checker #(.N_INSTR(N_INSTR), .N_LIT(N_LIT), .RAW(RAW)) u_chk (
  .clk_i, .rst_ni, .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_wdata_i,
  .if_valid_i, .if_addr_i, .if_valid_o, .if_addr_o, .if_match_o, .if_bkpt_o,
  .lit_match_o, .lit_addr_o, .en_q(ctrl_en), .base_q(base_full)
);

// File: tb/addr_patch_unit_tb.sv
`timescale 1ns/1ps
module addr_patch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid_i = 0, reg_write_i = 0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        if_valid_i = 0, lit_valid_i = 0;
  logic [31:0] if_addr_i = '0, lit_addr_i = '0;
  logic        if_valid_o, if_match_o, if_bkpt_o, lit_valid_o, lit_match_o;
  logic [31:0] if_addr_o, lit_addr_o;

  int checks = 0, failures = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  addr_patch_unit u_dut (
    .clk_i(clk), .rst_ni, .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .if_valid_i, .if_addr_i, .if_valid_o, .if_addr_o, .if_match_o,
    .if_bkpt_o, .lit_valid_i, .lit_addr_i, .lit_valid_o, .lit_addr_o, .lit_match_o
  );

  // behavioural model state
  bit          m_en;
  logic [31:0] m_base;
  bit          m_cen[8];
  int          m_mode[8];
  logic [31:0] m_cadr[8];
  bit          e_iv, e_im, e_ib, e_lv, e_lm;
  logic [31:0] e_ia, e_la;

  function automatic bit word_hit(int i, logic [31:0] a);
    return m_en && m_cen[i] && a[31:30] == 2'b00 && {a[31:2], 2'b00} == m_cadr[i];
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_en = 0; m_base = 0;
      for (int i = 0; i < 8; i++) begin m_cen[i] = 0; m_mode[i] = 0; m_cadr[i] = 0; end
      e_iv = 0; e_im = 0; e_ib = 0; e_lv = 0; e_lm = 0; e_ia = 0; e_la = 0;
    end else begin
      e_iv = if_valid_i; e_im = 0; e_ib = 0; e_ia = if_addr_i;
      if (if_valid_i) begin
        for (int i = 0; i < 6; i++) begin
          bit h;
          h = word_hit(i, if_addr_i) && (m_mode[i] == 0 || m_mode[i] == 3 ||
              (m_mode[i] == 1 && !if_addr_i[1]) || (m_mode[i] == 2 && if_addr_i[1]));
          if (h && !e_im && !e_ib) begin
            if (m_mode[i] == 0) begin e_im = 1; e_ia = m_base + 32'(4 * i) + 32'(if_addr_i[1:0]); end
            else e_ib = 1;
          end
        end
      end
      e_lv = lit_valid_i; e_lm = 0; e_la = lit_addr_i;
      if (lit_valid_i) begin
        for (int i = 6; i < 8; i++) begin
          if (word_hit(i, lit_addr_i) && !e_lm) begin
            e_lm = 1; e_la = m_base + 32'(4 * i) + 32'(lit_addr_i[1:0]);
          end
        end
      end
      if (reg_valid_i && reg_write_i) begin
        if (reg_addr_i == 0 && reg_wdata_i[1]) m_en = reg_wdata_i[0];
        if (reg_addr_i == 1) m_base = reg_wdata_i & ~32'h1f;
        if (reg_addr_i >= 2 && reg_addr_i <= 9) begin
          m_cen[reg_addr_i - 2]  = reg_wdata_i[0];
          m_mode[reg_addr_i - 2] = int'(reg_wdata_i[31:30]);
          m_cadr[reg_addr_i - 2] = {2'b00, reg_wdata_i[29:2], 2'b00};
        end
      end
    end
  end

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", t, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R11", "if_valid", 32'(if_valid_o), 32'(e_iv));
      chk("R11", "lit_valid", 32'(lit_valid_o), 32'(e_lv));
      chk(tag, "if_match", 32'(if_match_o), 32'(e_im));
      chk(tag, "if_bkpt", 32'(if_bkpt_o), 32'(e_ib));
      chk(tag, "lit_match", 32'(lit_match_o), 32'(e_lm));
      if (e_iv) chk(tag, "if_addr", if_addr_o, e_ia);
      if (e_lv) chk(tag, "lit_addr", lit_addr_o, e_la);
    end
  end

  task automatic drive(bit rv, bit rw, int ra, logic [31:0] wd, bit iv, logic [31:0] ia,
                       bit lv, logic [31:0] la);
    @(negedge clk);
    #1;
    reg_valid_i = rv; reg_write_i = rw; reg_addr_i = 4'(ra); reg_wdata_i = wd;
    if_valid_i = iv; if_addr_i = ia; lit_valid_i = lv; lit_addr_i = la;
  endtask

  task automatic wr(int ra, logic [31:0] wd);
    drive(1, 1, ra, wd, 0, 0, 0, 0);
  endtask

  task automatic fetch(logic [31:0] a);
    drive(0, 0, 0, 0, 1, a, 0, 0);
  endtask

  task automatic lit(logic [31:0] a);
    drive(0, 0, 0, 0, 0, 0, 1, a);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(int ra, logic [31:0] exp, string t);
    drive(1, 0, ra, 0, 0, 0, 0, 0);
    #1;
    chk(t, "rdata", reg_rdata_o, exp);
  endtask

  function automatic logic [31:0] cmpw(bit en, int mode, logic [31:0] a);
    return {2'(mode), a[29:2], 1'b0, en};
  endfunction

  initial begin
    #5000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #35 rst_ni = 1'b0;
    #20;
    chk("R1", "if_valid_rst", 32'(if_valid_o), 0);
    chk("R1", "if_match_rst", 32'(if_match_o), 0);
    chk("R1", "lit_match_rst", 32'(lit_match_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    tag = "R1"; rd(0, 32'h0000_0260, "R1");
    rd(1, 32'h0, "R1");
    // key lock
    tag = "R8";
    wr(0, 32'h1); rd(0, 32'h0000_0260, "R8");
    wr(0, 32'h3); rd(0, 32'h0000_0261, "R8");
    // base alignment
    tag = "R9";
    wr(1, 32'h2000_1234); rd(1, 32'h2000_1220, "R9");
    // comparator layout
    tag = "R10";
    wr(2, cmpw(1, 0, 32'h100)); rd(2, 32'h0000_0101, "R10");
    wr(9, cmpw(1, 2, 32'h0abc)); rd(9, 32'h8000_0abd, "R10");
    wr(9, 32'h0);
    // remap
    tag = "R2"; fetch(32'h100); fetch(32'h102); fetch(32'h103);
    tag = "R3"; fetch(32'h104); fetch(32'h0fc); idle();
    // priority: comparator 3 breaks at same word, comparator 0 still wins
    tag = "R4";
    wr(5, cmpw(1, 3, 32'h100)); fetch(32'h100); fetch(32'h102);
    wr(2, cmpw(0, 0, 32'h100)); fetch(32'h100);
    wr(3, cmpw(1, 3, 32'h180)); wr(4, cmpw(1, 0, 32'h180)); fetch(32'h180);
    // halfword break modes
    tag = "R5";
    wr(3, cmpw(1, 1, 32'h200)); fetch(32'h200); fetch(32'h202);
    wr(4, cmpw(1, 2, 32'h300)); fetch(32'h300); fetch(32'h302);
    wr(6, cmpw(1, 3, 32'h400)); fetch(32'h400); fetch(32'h403);
    // high address bits block a hit
    tag = "R10";
    wr(7, cmpw(1, 0, 32'h500)); fetch(32'h500); fetch(32'h4000_0500); fetch(32'hc000_0501);
    // literal comparators
    tag = "R6";
    wr(8, cmpw(1, 3, 32'h600)); wr(9, cmpw(1, 1, 32'h600));
    lit(32'h600); lit(32'h602);
    wr(8, cmpw(0, 3, 32'h600)); lit(32'h601);
    lit(32'h500); fetch(32'h600);
    drive(0, 0, 0, 0, 1, 32'h500, 1, 32'h602);
    // write and fetch in the same cycle: old config used
    tag = "R2";
    drive(1, 1, 7, cmpw(0, 0, 32'h500), 1, 32'h502, 0, 0); fetch(32'h502);
    drive(1, 1, 1, 32'h3000_0000, 1, 32'h200, 1, 32'h600); fetch(32'h100); lit(32'h600);
    // global disable
    tag = "R7";
    wr(0, 32'h2); fetch(32'h200); lit(32'h600); fetch(32'h400);
    wr(0, 32'h1); fetch(32'h200); rd(0, 32'h0000_0260, "R8");
    wr(0, 32'h3); fetch(32'h200); lit(32'h604); lit(32'h600);
    tag = "R11"; idle(); idle(); idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule